// File: doc/BRIEF.md
# Clock Correction Sequence Matcher

This block watches a decoded receive symbol stream and raises a one-cycle strobe whenever a programmed clock correction sequence has just been received. Each symbol carries an 8-bit value, a control flag and a disparity-error flag. The error flag is how a control character sent as a deliberate disparity violation is recognised. Up to two independent sequences can be programmed. All enabled sequences share one length of 1, 2 or 4 symbols. Any symbol position of any sequence can be masked so that it always matches.

The matcher keeps the three previously accepted symbols in a shift register. A sequence that ends on the current symbol is therefore compared in a single cycle. Cycles with the valid input low are idle: they neither advance the history nor produce a match. A match reports which sequence was seen. It also reports the stream index of the sequence's first symbol, taken from a symbol counter that starts at zero after reset. Decoding, elastic buffering and the insertion or deletion of symbols are handled elsewhere.

Top module: `ccs_matcher`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `match_o` is 0.
- R2: When `cfg_seq_cnt_i` is 0, `match_o` never asserts, whatever symbols arrive.
- R3: `cfg_len_i` selects the sequence length: 0 selects 1 symbol, 1 selects 2 symbols, and 2 or 3 select 4 symbols. Pattern position p of a sequence of length L is compared with the symbol received L-1-p accepted symbols before the current one, so position 0 is the oldest symbol.
- R4: An unmasked position matches only when the received 8-bit value equals the value in `cfg_val_i`. Sequence s, position p, occupies bits [(s*4+p)*8 +: 8].
- R5: An unmasked position matches only when `sym_ctrl_i` equals the position's bit s*4+p of `cfg_k_i`.
- R6: An unmasked position matches only when `sym_derr_i` equals the position's bit s*4+p of `cfg_inv_i`. A set bit therefore requires the disparity-error indication, and a clear bit requires its absence.
- R7: A position whose bit s*4+p of `cfg_dc_i` is set always matches.
- R8: Sequence s takes part only when `cfg_seq_cnt_i` is greater than s. A value of 1 enables sequence 0 alone, and 2 or 3 enable both sequences.
- R9: When both sequences match on the same symbol, `match_seq_o` reports 0.
- R10: `match_o` is high for exactly the one cycle after the clock edge that accepts the last symbol of a matching window. Every occurrence is flagged, including overlapping ones. Idle cycles (`sym_valid_i` low) give no match and do not break a window.
- R11: With `match_o`, `match_start_o` equals the index of the window's first symbol: the number of symbols accepted since reset before it, modulo 2^CNT_W.
- R12: A sequence of length L can match only once at least L symbols have been accepted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol present this cycle |
| sym_data_i | input | 8 | Received symbol value |
| sym_ctrl_i | input | 1 | Received symbol is a control character |
| sym_derr_i | input | 1 | Received symbol had a disparity error |
| cfg_seq_cnt_i | input | 2 | Number of enabled sequences (0 disables matching) |
| cfg_len_i | input | 2 | Length select: 0 = 1, 1 = 2, 2/3 = 4 symbols |
| cfg_val_i | input | 64 | Pattern values, 8 bits per sequence/position |
| cfg_k_i | input | 8 | Pattern control flags |
| cfg_inv_i | input | 8 | Pattern disparity-error requirement |
| cfg_dc_i | input | 8 | Pattern position masks |
| match_o | output | 1 | One-cycle match strobe |
| match_seq_o | output | 1 | Index of the matching sequence |
| match_start_o | output | 16 | Stream index of the first symbol of the match |

## Verification
The bound checker enforces the following on every cycle:
- silence while matching is disabled;
- that each strobe follows an accepted symbol;
- that sequence 1 is never reported unless it is enabled;
- that enough history exists for the programmed length;
- that the start index agrees with an independent symbol count;
- that a single-symbol match of sequence 0 carries the programmed value, control flag and disparity flag.

Other behaviours can only be shown by the bench's scenarios against its reference model. These are the rejection of each mismatching field, masked positions in the middle of a window, the window order across idle cycles, back-to-back and overlapping strobes, and priority when both sequences match on one symbol.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int SYM_W = 8;
  localparam int MAX_LEN = 4;

  typedef struct packed {
    logic [SYM_W-1:0] data;
    logic             ctrl;
    logic             derr;
  } sym_t;
endpackage

// File: rtl/ccs_history.sv
module ccs_history
  import ccs_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int CNT_W  = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_i,
  input  sym_t                   sym_i,
  output sym_t [DEPTH-1:0]       hist_o,
  output logic [FILL_W-1:0]      fill_o,
  output logic [CNT_W-1:0]       idx_o
);
  sym_t [DEPTH-1:0]  hist_q;
  logic [FILL_W-1:0] fill_q;
  logic [CNT_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (shift_i) begin
      hist_q[0] <= sym_i;
      for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
    end
  end

  // saturating count of symbols held, gates short-history matches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      idx_q  <= '0;
    end else if (shift_i) begin
      if (fill_q != FILL_W'(DEPTH)) fill_q <= fill_q + 1'b1;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign hist_o = hist_q;
  assign fill_o = fill_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/ccs_pos_cmp.sv
module ccs_pos_cmp
  import ccs_pkg::*;
(
  input  sym_t             rx_i,
  input  logic [SYM_W-1:0] val_i,
  input  logic             k_i,
  input  logic             inv_i,
  input  logic             dc_i,
  output logic             ok_o
);
  assign ok_o = dc_i | ((rx_i.data == val_i) & (rx_i.ctrl == k_i) & (rx_i.derr == inv_i));
endmodule

// File: rtl/ccs_seq_cmp.sv
module ccs_seq_cmp
  import ccs_pkg::*;
#(
  parameter int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  sym_t [MAX_LEN-1:0]       win_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic                     avail_i,
  input  logic [MAX_LEN*SYM_W-1:0] val_i,
  input  logic [MAX_LEN-1:0]       k_i,
  input  logic [MAX_LEN-1:0]       inv_i,
  input  logic [MAX_LEN-1:0]       dc_i,
  output logic                     hit_o
);
  sym_t [MAX_LEN-1:0] pos_sym;
  logic [MAX_LEN-1:0] used;
  logic [MAX_LEN-1:0] pos_ok;

  // position p lines up with the symbol of age len-1-p
  always_comb begin
    for (int p = 0; p < MAX_LEN; p++) begin
      used[p]    = int'(len_i) > p;
      pos_sym[p] = '0;
      for (int a = 0; a < MAX_LEN; a++) begin
        if (int'(len_i) - 1 - p == a) pos_sym[p] = win_i[a];
      end
    end
  end

  for (genvar p = 0; p < MAX_LEN; p++) begin : g_pos
    ccs_pos_cmp u_pos (
      .rx_i  (pos_sym[p]),
      .val_i (val_i[p*SYM_W +: SYM_W]),
      .k_i   (k_i[p]),
      .inv_i (inv_i[p]),
      .dc_i  (dc_i[p]),
      .ok_o  (pos_ok[p])
    );
  end

  assign hit_o = avail_i & (&(pos_ok | ~used));
endmodule

// File: rtl/ccs_matcher.sv
module ccs_matcher
  import ccs_pkg::*;
#(
  parameter int NUM_SEQ = 2,
  parameter int CNT_W   = 16,
  parameter int SEQ_W   = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1,
  parameter int SEL_W   = $clog2(NUM_SEQ + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sym_valid_i,
  input  logic [SYM_W-1:0]               sym_data_i,
  input  logic                           sym_ctrl_i,
  input  logic                           sym_derr_i,
  input  logic [SEL_W-1:0]               cfg_seq_cnt_i,
  input  logic [1:0]                     cfg_len_i,
  input  logic [NUM_SEQ*MAX_LEN*SYM_W-1:0] cfg_val_i,
  input  logic [NUM_SEQ*MAX_LEN-1:0]     cfg_k_i,
  input  logic [NUM_SEQ*MAX_LEN-1:0]     cfg_inv_i,
  input  logic [NUM_SEQ*MAX_LEN-1:0]     cfg_dc_i,
  output logic                           match_o,
  output logic [SEQ_W-1:0]               match_seq_o,
  output logic [CNT_W-1:0]               match_start_o
);
  localparam int DEPTH  = MAX_LEN - 1;
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam int LEN_W  = $clog2(MAX_LEN + 1);

  sym_t                 cur_sym;
  sym_t [DEPTH-1:0]     hist;
  sym_t [MAX_LEN-1:0]   win;
  logic [FILL_W-1:0]    fill;
  logic [CNT_W-1:0]     idx;
  logic [LEN_W-1:0]     len_n;
  logic                 avail;
  logic [NUM_SEQ-1:0]   hit, hit_en;
  logic                 hit_any;
  logic [SEQ_W-1:0]     hit_idx;

  logic                 match_q;
  logic [SEQ_W-1:0]     seq_q;
  logic [CNT_W-1:0]     start_q;

  assign cur_sym = '{data: sym_data_i, ctrl: sym_ctrl_i, derr: sym_derr_i};

  always_comb begin
    unique case (cfg_len_i)
      2'd0:    len_n = LEN_W'(1);
      2'd1:    len_n = LEN_W'(2);
      default: len_n = LEN_W'(4);
    endcase
  end

  ccs_history #(.DEPTH(DEPTH), .CNT_W(CNT_W), .FILL_W(FILL_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sym_valid_i),
    .sym_i   (cur_sym),
    .hist_o  (hist),
    .fill_o  (fill),
    .idx_o   (idx)
  );

  assign win[0] = cur_sym;
  for (genvar k = 1; k < MAX_LEN; k++) begin : g_win
    assign win[k] = hist[k-1];
  end

  assign avail = int'(fill) >= int'(len_n) - 1;

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    ccs_seq_cmp #(.LEN_W(LEN_W)) u_seq (
      .win_i   (win),
      .len_i   (len_n),
      .avail_i (avail),
      .val_i   (cfg_val_i[s*MAX_LEN*SYM_W +: MAX_LEN*SYM_W]),
      .k_i     (cfg_k_i[s*MAX_LEN +: MAX_LEN]),
      .inv_i   (cfg_inv_i[s*MAX_LEN +: MAX_LEN]),
      .dc_i    (cfg_dc_i[s*MAX_LEN +: MAX_LEN]),
      .hit_o   (hit[s])
    );
    assign hit_en[s] = hit[s] & (int'(cfg_seq_cnt_i) > s);
  end

  // lowest index wins
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int s = NUM_SEQ - 1; s >= 0; s--) begin
      if (hit_en[s]) begin
        hit_any = 1'b1;
        hit_idx = SEQ_W'(s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      seq_q   <= '0;
      start_q <= '0;
    end else begin
      match_q <= sym_valid_i & hit_any;
      if (sym_valid_i & hit_any) begin
        seq_q   <= hit_idx;
        start_q <= idx - CNT_W'(len_n) + 1'b1;
      end
    end
  end

  assign match_o       = match_q;
  assign match_seq_o   = seq_q;
  assign match_start_o = start_q;
endmodule

// File: rtl/ccs_matcher_chk.sv
module ccs_matcher_chk
  import ccs_pkg::*;
#(
  parameter int NUM_SEQ = 2,
  parameter int CNT_W   = 16,
  parameter int SEQ_W   = 1,
  parameter int SEL_W   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sym_valid_i,
  input logic [SYM_W-1:0] sym_data_i,
  input logic             sym_ctrl_i,
  input logic             sym_derr_i,
  input logic [SEL_W-1:0] cfg_seq_cnt_i,
  input logic [1:0]       cfg_len_i,
  input logic [SYM_W-1:0] cfg_val0_i,
  input logic             cfg_k0_i,
  input logic             cfg_inv0_i,
  input logic             cfg_dc0_i,
  input logic             match_o,
  input logic [SEQ_W-1:0] match_seq_o,
  input logic [CNT_W-1:0] match_start_o
);
  logic [CNT_W-1:0] cnt_q, exp_start_q;
  logic [2:0]       seen_q;
  logic [2:0]       len_c;
  logic             enough_c;

  assign len_c    = (cfg_len_i == 2'd0) ? 3'd1 : (cfg_len_i == 2'd1) ? 3'd2 : 3'd4;
  assign enough_c = (seen_q + 3'd1) >= len_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      seen_q      <= '0;
      exp_start_q <= '0;
    end else if (sym_valid_i) begin
      cnt_q       <= cnt_q + 1'b1;
      if (seen_q != 3'd3) seen_q <= seen_q + 1'b1;
      exp_start_q <= cnt_q + 1'b1 - CNT_W'(len_c);
    end
  end

  // R2
  off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_seq_cnt_i) == '0 |-> !match_o);

  // R10
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(sym_valid_i));

  // R8
  seq_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && match_seq_o != '0) |-> int'($past(cfg_seq_cnt_i)) >= 2);

  // R11
  start_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> match_start_o == exp_start_q);

  // R12
  history_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(enough_c));

  // R4 R5 R6
  single_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && match_seq_o == '0 && $past(cfg_len_i) == 2'd0 && !$past(cfg_dc0_i))
    |-> ($past(sym_data_i) == $past(cfg_val0_i) && $past(sym_ctrl_i) == $past(cfg_k0_i)
         && $past(sym_derr_i) == $past(cfg_inv0_i)));
endmodule

bind ccs_matcher ccs_matcher_chk #(
  .NUM_SEQ(NUM_SEQ), .CNT_W(CNT_W), .SEQ_W(SEQ_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sym_valid_i   (sym_valid_i),
  .sym_data_i    (sym_data_i),
  .sym_ctrl_i    (sym_ctrl_i),
  .sym_derr_i    (sym_derr_i),
  .cfg_seq_cnt_i (cfg_seq_cnt_i),
  .cfg_len_i     (cfg_len_i),
  .cfg_val0_i    (cfg_val_i[ccs_pkg::SYM_W-1:0]),
  .cfg_k0_i      (cfg_k_i[0]),
  .cfg_inv0_i    (cfg_inv_i[0]),
  .cfg_dc0_i     (cfg_dc_i[0]),
  .match_o       (match_o),
  .match_seq_o   (match_seq_o),
  .match_start_o (match_start_o)
);

// File: tb/ccs_matcher_test.sv
`timescale 1ns/1ps
module ccs_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_valid = 1'b0;
  logic [7:0]  sym_data = '0;
  logic        sym_ctrl = 1'b0;
  logic        sym_derr = 1'b0;
  logic [1:0]  cfg_seq_cnt = '0;
  logic [1:0]  cfg_len = '0;
  logic [63:0] cfg_val = '0;
  logic [7:0]  cfg_k = '0, cfg_inv = '0, cfg_dc = '0;
  logic        match;
  logic [0:0]  match_seq;
  logic [15:0] match_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] d; logic k; logic e; } bsym_t;
  bsym_t hq[$];
  int unsigned sym_cnt = 0;
  bit          exp_match = 0;
  int          exp_seq = 0;
  int unsigned exp_start = 0;

  always #2 clk = ~clk;

  ccs_matcher uut (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_data_i(sym_data),
    .sym_ctrl_i(sym_ctrl), .sym_derr_i(sym_derr), .cfg_seq_cnt_i(cfg_seq_cnt),
    .cfg_len_i(cfg_len), .cfg_val_i(cfg_val), .cfg_k_i(cfg_k), .cfg_inv_i(cfg_inv),
    .cfg_dc_i(cfg_dc), .match_o(match), .match_seq_o(match_seq), .match_start_o(match_start)
  );

  function automatic int len_of(logic [1:0] sel);
    return (sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 4;
  endfunction

  task automatic model_edge(bsym_t cur);
    int L;
    bit ok;
    bsym_t s;
    exp_match = 0;
    L = len_of(cfg_len);
    for (int q = 0; q < 2 && !exp_match; q++) begin
      if (q < int'(cfg_seq_cnt) && hq.size() >= L - 1) begin
        ok = 1;
        for (int p = 0; p < L; p++) begin
          int age = L - 1 - p;
          int i = q * 4 + p;
          s = (age == 0) ? cur : hq[hq.size() - age];
          if (!cfg_dc[i] && !(s.d == cfg_val[i*8 +: 8] && s.k == cfg_k[i] && s.e == cfg_inv[i]))
            ok = 0;
        end
        if (ok) begin
          exp_match = 1;
          exp_seq   = q;
          exp_start = (sym_cnt - (L - 1)) & 32'hFFFF;
        end
      end
    end
    hq.push_back(cur);
    if (hq.size() > 3) void'(hq.pop_front());
    sym_cnt++;
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input string tag, input bit v, input logic [7:0] d, input bit k, input bit e);
    bsym_t cur;
    sym_valid = v; sym_data = d; sym_ctrl = k; sym_derr = e;
    @(posedge clk);
    if (v) begin
      cur.d = d; cur.k = k; cur.e = e;
      model_edge(cur);
    end else begin
      exp_match = 0;
    end
    @(negedge clk);
    sym_valid = 0;
    checks++;
    if (match !== exp_match ||
        (exp_match && (int'(match_seq) != exp_seq || int'(match_start) != int'(exp_start)))) begin
      errors++;
      $display("FAIL %s: match=%0b seq=%0d start=%0d expected match=%0b seq=%0d start=%0d",
               tag, match, match_seq, match_start, exp_match, exp_seq, exp_start);
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 8'h00, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 0; sym_valid = 0;
    hq.delete(); sym_cnt = 0; exp_match = 0;
    @(negedge clk); @(negedge clk);
    checks++;
    if (match !== 1'b0) begin
      errors++;
      $display("FAIL R1: match=%0b during reset expected 0", match);
    end
    rst_n = 1;
  endtask

  task automatic clr_pats();
    cfg_val = '0; cfg_k = '0; cfg_inv = '0; cfg_dc = '0;
  endtask

  task automatic set_pat(input int s, input int p, input logic [7:0] v, input bit k, input bit inv, input bit dc);
    cfg_val[(s*4+p)*8 +: 8] = v;
    cfg_k[s*4+p] = k; cfg_inv[s*4+p] = inv; cfg_dc[s*4+p] = dc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    idle("R1");

    // R2: disabled
    cfg_seq_cnt = 0; cfg_len = 0; clr_pats(); set_pat(0, 0, 8'hBC, 1, 0, 0);
    step("R2", 1, 8'hBC, 1, 0);
    step("R2", 1, 8'hBC, 1, 0);
    step("R2", 1, 8'hBC, 1, 0);

    // single-symbol field checks
    cfg_seq_cnt = 1;
    step("R4", 1, 8'hBC, 1, 0);
    step("R5", 1, 8'hBC, 0, 0);
    step("R4", 1, 8'hBD, 1, 0);
    step("R6", 1, 8'hBC, 1, 1);
    idle("R10");
    step("R10", 1, 8'hBC, 1, 0);
    step("R10", 1, 8'hBC, 1, 0);
    idle("R10");

    // R3: two-symbol order and idle gaps
    cfg_len = 1; clr_pats(); set_pat(0, 0, 8'h1C, 1, 0, 0); set_pat(0, 1, 8'h3C, 1, 0, 0);
    step("R3", 1, 8'h3C, 1, 0);
    step("R3", 1, 8'h1C, 1, 0);
    step("R3", 1, 8'h3C, 1, 0);
    step("R10", 1, 8'h1C, 1, 0);
    idle("R10");
    idle("R10");
    step("R10", 1, 8'h3C, 1, 0);
    step("R3", 1, 8'h1C, 1, 0);

    // R7: four symbols, masked position 1
    cfg_len = 2; clr_pats();
    for (int p = 0; p < 4; p++) set_pat(0, p, 8'hF7, 1, 0, p == 1);
    step("R7", 1, 8'hF7, 1, 0);
    step("R7", 1, 8'h00, 0, 1);
    step("R7", 1, 8'hF7, 1, 0);
    step("R11", 1, 8'hF7, 1, 0);
    step("R10", 1, 8'hF7, 1, 0);

    // R8: second sequence
    cfg_seq_cnt = 2;
    set_pat(1, 0, 8'h1C, 1, 0, 0); set_pat(1, 1, 8'hBC, 1, 0, 0);
    set_pat(1, 2, 8'hBC, 1, 0, 0); set_pat(1, 3, 8'h3C, 1, 0, 0);
    step("R8", 1, 8'h1C, 1, 0);
    step("R8", 1, 8'hBC, 1, 0);
    step("R8", 1, 8'hBC, 1, 0);
    step("R8", 1, 8'h3C, 1, 0);
    cfg_seq_cnt = 1;
    step("R8", 1, 8'h1C, 1, 0);
    step("R8", 1, 8'hBC, 1, 0);
    step("R8", 1, 8'hBC, 1, 0);
    step("R8", 1, 8'h3C, 1, 0);

    // R9: priority
    cfg_seq_cnt = 3; cfg_len = 0; clr_pats();
    set_pat(0, 0, 8'hBC, 1, 0, 0); set_pat(1, 0, 8'h00, 0, 0, 1);
    step("R9", 1, 8'hBC, 1, 0);
    step("R9", 1, 8'h42, 0, 0);
    step("R9", 1, 8'hBC, 1, 0);

    // R6: disparity-error marker required
    cfg_seq_cnt = 1; clr_pats(); set_pat(0, 0, 8'h55, 0, 1, 0);
    step("R6", 1, 8'h55, 0, 1);
    step("R6", 1, 8'h55, 0, 0);
    step("R6", 1, 8'h55, 1, 1);

    // R12: history after reset, length select 3 behaves as four
    do_reset();
    cfg_seq_cnt = 1; cfg_len = 3; clr_pats();
    for (int p = 0; p < 4; p++) set_pat(0, p, 8'h00, 0, 0, 1);
    step("R12", 1, 8'h11, 0, 0);
    step("R12", 1, 8'h22, 0, 0);
    idle("R12");
    step("R12", 1, 8'h33, 0, 0);
    step("R12", 1, 8'h44, 0, 0);
    step("R11", 1, 8'h55, 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule